// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors held in system memory and turns the buffers they point at into a byte stream. Software prepares descriptors and programs the ring start address. It then pulses an activate input while the controller enable is set. The engine reads descriptors one after another and streams each buffer's bytes out. It joins consecutive buffers into one frame until it meets a descriptor marked as the final one of the frame.

After each buffer the engine writes the descriptor's first word back to memory with the ready flag cleared. It then moves to the next slot, or returns to the ring start when the descriptor carries the wrap flag. A frame that would exceed `MAX_FRAME` bytes is cut short and a babble event is raised. Single-cycle event pulses report each finished buffer and each finished frame. The engine stops at the first descriptor that software has not marked ready, and the next activation resumes from that slot.

Top module: `txring_engine`

## Requirements
- R1: An activate pulse starts a walk only when `cfg_enable` is high and the engine is idle. With `cfg_enable` low the pulse is ignored: no memory request is issued and `busy` stays low.
- R2: A descriptor is two 32-bit words. The word at the descriptor address holds the byte length in bits 15:0 and flags in bits 31:16: ready in bit 31, wrap in bit 29, last-in-frame in bit 27. The word at address+4 holds the byte address of the buffer.
- R3: The walk ends at the first descriptor whose ready bit is clear. That descriptor is neither written back nor counted, and the next activation starts by reading that same descriptor address.
- R4: After a descriptor is processed the next one is read at the current address plus 8, or at the ring start when the wrap bit was set.
- R5: Buffer bytes leave in ascending address order at any byte alignment, with byte k of a memory word taken from bits 8k+7:8k. The buffers of consecutive descriptors are joined, and `out_last` marks the final byte of a frame, which ends at a descriptor with the last bit set.
- R6: When a buffer would take the frame past `MAX_FRAME` bytes, only the bytes that still fit are sent, the rest are dropped, and `evt_babble` pulses with that descriptor's buffer event.
- R7: Each processed descriptor is written back at its own address with bit 31 cleared and every other bit unchanged. `evt_buf` pulses once for it, and `evt_frame` also pulses when its last bit is set.
- R8: Writing the ring start forces address bits 1:0 to zero and moves the current descriptor pointer to that address.
- R9: A memory request keeps its address, direction and write data until it is granted. A byte offered on the output keeps its data and end marker until it is accepted.
- R10: Out of reset the engine is idle, with no memory request, no output byte and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Controller enable; activation is ignored while low |
| tx_kick | input | 1 | Activate pulse that starts a ring walk |
| ring_base_wr | input | 1 | Strobe that loads the ring start address |
| ring_base_data | input | ADDR_W | Ring start address value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | ADDR_W | Word address of the access (bits 1:0 zero) |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; completes the access in this cycle |
| mem_rdata | input | 32 | Read data, valid together with the grant |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a frame |
| out_ready | input | 1 | Sink accepts the output byte |
| evt_buf | output | 1 | Pulse: one descriptor processed |
| evt_frame | output | 1 | Pulse: frame completed |
| evt_babble | output | 1 | Pulse: buffer truncated at the frame limit |
| busy | output | 1 | Engine is walking the ring |

## Verification
The bench builds the engine with `MAX_FRAME` set to 16. At that size truncation can be reached with a single 20-byte buffer, a buffer split across the limit, and a later buffer that has no room left at all. It sweeps every length from 1 to 8 against every start alignment from 0 to 3, so each path through a partial first word and a partial last word is exercised. The bench also varies the grant latency and the sink's ready pattern, and it compares the bytes, end markers, event counts, write-backs and the address of the first fetch against values worked out from the descriptors it wrote.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_D0,
    S_RD_D1,
    S_RD_BUF,
    S_EMIT,
    S_FLUSH,
    S_WB
  } txr_state_e;

  // Flag positions inside the first descriptor word
  localparam int FLAG_READY = 31;
  localparam int FLAG_WRAP  = 29;
  localparam int FLAG_LAST  = 27;
  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr import txr_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  input  logic              step,
  input  logic              step_wrap,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [ADDR_W-1:0] cur_q, cur_n;

  always_comb begin
    base_n = base_q;
    cur_n  = cur_q;
    if (base_wr) begin
      base_n = base_data & ~ADDR_W'(3);
      cur_n  = base_data & ~ADDR_W'(3);
    end else if (step) begin
      cur_n = step_wrap ? base_q : cur_q + ADDR_W'(DESC_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      base_q <= base_n;
      cur_q  <= cur_n;
    end
  end

  assign cur_addr = cur_q;
endmodule

// File: rtl/txr_clip.sv
module txr_clip #(
  parameter int LEN_W     = 16,
  parameter int FSZ_W     = 12,
  parameter int MAX_FRAME = 2048
) (
  input  logic [FSZ_W-1:0] fsize,
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W-1:0] eff_len,
  output logic             trunc
);
  localparam int RW = LEN_W + 1;
  logic [RW-1:0] room;

  always_comb begin
    room    = RW'(MAX_FRAME) - RW'(fsize);
    trunc   = {1'b0, req_len} > room;
    eff_len = trunc ? room[LEN_W-1:0] : req_len;
  end
endmodule

// File: rtl/txr_byte_out.sv
module txr_byte_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_byte,
  input  logic       flush,
  input  logic       out_ready,
  output logic       take,
  output logic       flush_done,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  logic       pend_v_q, pend_v_n;
  logic [7:0] pend_b_q, pend_b_n;

  // One byte is held back so the end marker can be attached at frame end
  always_comb begin
    take       = push && (!pend_v_q || out_ready);
    flush_done = flush && (!pend_v_q || out_ready);
    pend_v_n   = pend_v_q;
    pend_b_n   = pend_b_q;
    if (take) begin
      pend_v_n = 1'b1;
      pend_b_n = push_byte;
    end else if (flush_done) begin
      pend_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_b_q <= '0;
    end else begin
      pend_v_q <= pend_v_n;
      if (take) pend_b_q <= pend_b_n;
    end
  end

  assign out_valid = pend_v_q && (push || flush);
  assign out_data  = pend_b_q;
  assign out_last  = flush;

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_push_flush_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && flush));
endmodule

// File: rtl/txring_engine.sv
module txring_engine import txr_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              tx_kick,
  input  logic              ring_base_wr,
  input  logic [ADDR_W-1:0] ring_base_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              evt_buf,
  output logic              evt_frame,
  output logic              evt_babble,
  output logic              busy
);
  localparam int FSZ_W = $clog2(MAX_FRAME + 1);

  txr_state_e        state_q, state_n;
  logic [31:0]       word0_q, word0_n;
  logic [31:0]       bufw_q, bufw_n;
  logic [ADDR_W-1:0] baddr_q, baddr_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [FSZ_W-1:0]  fsize_q, fsize_n;
  logic              trunc_q, trunc_n;

  logic [ADDR_W-1:0] cur_addr;
  logic              step;
  logic [LEN_W-1:0]  clip_len;
  logic              clip_trunc;
  logic              push, flush, take, flush_done;
  logic [7:0]        cur_byte;
  logic              is_last;

  txr_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_wr   (ring_base_wr),
    .base_data (ring_base_data),
    .step      (step),
    .step_wrap (word0_q[FLAG_WRAP]),
    .cur_addr  (cur_addr)
  );

  txr_clip #(.LEN_W(LEN_W), .FSZ_W(FSZ_W), .MAX_FRAME(MAX_FRAME)) u_clip (
    .fsize   (fsize_q),
    .req_len (mem_rdata[LEN_W-1:0]),
    .eff_len (clip_len),
    .trunc   (clip_trunc)
  );

  txr_byte_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_byte  (cur_byte),
    .flush      (flush),
    .out_ready  (out_ready),
    .take       (take),
    .flush_done (flush_done),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last)
  );

  assign is_last  = word0_q[FLAG_LAST];
  assign cur_byte = bufw_q[{baddr_q[1:0], 3'b000} +: 8];

  always_comb begin
    state_n = state_q;
    word0_n = word0_q;
    bufw_n  = bufw_q;
    baddr_n = baddr_q;
    rem_n   = rem_q;
    fsize_n = fsize_q;
    trunc_n = trunc_q;
    step    = 1'b0;
    push    = 1'b0;
    flush   = 1'b0;
    case (state_q)
      S_IDLE: if (tx_kick && cfg_enable) state_n = S_RD_D0;
      S_RD_D0: if (mem_gnt) begin
        if (!mem_rdata[FLAG_READY]) begin
          state_n = S_IDLE;
        end else begin
          word0_n = mem_rdata;
          rem_n   = clip_len;
          trunc_n = clip_trunc;
          fsize_n = fsize_q + FSZ_W'(clip_len);
          state_n = S_RD_D1;
        end
      end
      S_RD_D1: if (mem_gnt) begin
        baddr_n = mem_rdata[ADDR_W-1:0];
        if (rem_q == '0) state_n = is_last ? S_FLUSH : S_WB;
        else             state_n = S_RD_BUF;
      end
      S_RD_BUF: if (mem_gnt) begin
        bufw_n  = mem_rdata;
        state_n = S_EMIT;
      end
      S_EMIT: begin
        push = 1'b1;
        if (take) begin
          baddr_n = baddr_q + ADDR_W'(1);
          rem_n   = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1))          state_n = is_last ? S_FLUSH : S_WB;
          else if (baddr_q[1:0] == 2'b11)  state_n = S_RD_BUF;
        end
      end
      S_FLUSH: begin
        flush = 1'b1;
        if (flush_done) state_n = S_WB;
      end
      S_WB: if (mem_gnt) begin
        step    = 1'b1;
        if (is_last) fsize_n = '0;
        state_n = S_RD_D0;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      word0_q <= '0;
      bufw_q  <= '0;
      baddr_q <= '0;
      rem_q   <= '0;
      fsize_q <= '0;
      trunc_q <= 1'b0;
    end else begin
      state_q <= state_n;
      word0_q <= word0_n;
      bufw_q  <= bufw_n;
      baddr_q <= baddr_n;
      rem_q   <= rem_n;
      fsize_q <= fsize_n;
      trunc_q <= trunc_n;
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_addr;
    case (state_q)
      S_RD_D0:  mem_req = 1'b1;
      S_RD_D1: begin mem_req = 1'b1; mem_addr = cur_addr + ADDR_W'(4); end
      S_RD_BUF: begin mem_req = 1'b1; mem_addr = {baddr_q[ADDR_W-1:2], 2'b00}; end
      S_WB:    begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign mem_wdata  = {1'b0, word0_q[30:0]};
  assign evt_buf    = (state_q == S_WB) && mem_gnt;
  assign evt_frame  = evt_buf && is_last;
  assign evt_babble = evt_buf && trunc_q;
  assign busy       = (state_q != S_IDLE);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_kick_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cfg_enable |=> !busy);

  assert_stop_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_RD_D0 && mem_gnt && !mem_rdata[FLAG_READY] |=> !busy && !mem_req);

  assert_frame_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fsize_q <= FSZ_W'(MAX_FRAME));

  assert_end_then_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> mem_req && mem_we);
endmodule

// File: tb/txring_engine_test.sv
module txring_engine_test;
  localparam int MAXF = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, tx_kick, ring_base_wr;
  logic [31:0] ring_base_data;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_last, out_ready;
  logic [7:0]  out_data;
  logic        evt_buf, evt_frame, evt_babble, busy;

  always #2 clk = ~clk;

  txring_engine #(.ADDR_W(32), .LEN_W(16), .MAX_FRAME(MAXF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .tx_kick(tx_kick),
    .ring_base_wr(ring_base_wr), .ring_base_data(ring_base_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .evt_buf(evt_buf), .evt_frame(evt_frame), .evt_babble(evt_babble), .busy(busy)
  );

  logic [31:0] mem [0:1023];
  logic [7:0]  rx_q[$];
  logic        rxl_q[$];
  logic [7:0]  ex_q[$];
  logic        exl_q[$];
  int n_chk = 0, n_fail = 0;
  int n_buf = 0, n_frm = 0, n_bab = 0;
  int cyc = 0, lat_cnt = 0, lat_seed = 1, rdy_mode = 0;
  int first_addr = -1;
  logic cap_first = 1'b0, saw_req = 1'b0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setd(input int a, input logic rdy, input logic wrap, input logic last,
                      input int len, input int bufa);
    mem[a >> 2]       = {rdy, 1'b0, wrap, 1'b0, last, 11'd0, 16'(len)};
    mem[(a >> 2) + 1] = 32'(bufa);
  endtask

  task automatic expect_bytes(input int a, input int n, input logic ends);
    for (int i = 0; i < n; i++) begin
      ex_q.push_back(pat(a + i));
      exl_q.push_back(ends && (i == n - 1));
    end
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(rx_q.size() == ex_q.size(), req, rx_q.size(), ex_q.size());
    if (rx_q.size() == ex_q.size()) begin
      for (int i = 0; i < ex_q.size(); i++)
        if (bad < 0 && (rx_q[i] != ex_q[i] || rxl_q[i] != exl_q[i])) bad = i;
      if (bad >= 0) chk(1'b0, req, {rxl_q[bad], rx_q[bad]}, {exl_q[bad], ex_q[bad]});
      else          chk(1'b1, req, 0, 0);
    end
    rx_q.delete(); rxl_q.delete(); ex_q.delete(); exl_q.delete();
  endtask

  task automatic counts(input string req, input int b, input int f, input int k);
    chk(n_buf == b && n_frm == f && n_bab == k, req,
        (n_buf << 16) | (n_frm << 8) | n_bab, (b << 16) | (f << 8) | k);
    n_buf = 0; n_frm = 0; n_bab = 0;
  endtask

  task automatic set_base(input int a);
    @(negedge clk); ring_base_wr = 1'b1; ring_base_data = 32'(a);
    @(negedge clk); ring_base_wr = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); cap_first = 1'b1; tx_kick = 1'b1;
    @(negedge clk); tx_kick = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  // Memory responder, sink and monitor, all stepping at the falling edge
  initial begin
    mem_gnt = 1'b0; mem_rdata = '0; out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        mem_gnt = 1'b0;
      end else if (mem_gnt) begin
        mem_gnt  = 1'b0;
        lat_seed = (lat_seed * 5 + 1) % 7;
        lat_cnt  = lat_seed % 4;
      end else if (mem_req) begin
        if (lat_cnt == 0) begin
          mem_gnt = 1'b1;
          if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[11:2]];
        end else lat_cnt--;
      end
      out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      #1;
      if (out_valid && out_ready) begin rx_q.push_back(out_data); rxl_q.push_back(out_last); end
      if (evt_buf)    n_buf++;
      if (evt_frame)  n_frm++;
      if (evt_babble) n_bab++;
      if (mem_req) saw_req = 1'b1;
      if (cap_first && mem_req) begin first_addr = int'(mem_addr); cap_first = 1'b0; end
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; tx_kick = 1'b0; ring_base_wr = 1'b0; ring_base_data = '0;
    for (int w = 0; w < 1024; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    for (int w = 64; w < 256; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    chk(!mem_req && !out_valid && !busy && !evt_buf && !evt_frame && !evt_babble, "R10",
        {mem_req, out_valid, busy, evt_buf}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_req && !out_valid && !busy, "R10", {mem_req, out_valid, busy}, 0);

    // R1: activation ignored while disabled
    set_base(32'h102);
    setd(32'h100, 1, 0, 1, 4, 32'h400);
    saw_req = 1'b0;
    kick();
    repeat (10) @(negedge clk);
    chk(!saw_req && !busy && rx_q.size() == 0, "R1", {saw_req, busy}, 0);
    cap_first = 1'b0;

    // R2 R5 R6 R7: gathered frame, then a truncated frame, stop at not-ready slot
    cfg_enable = 1'b1;
    setd(32'h100, 1, 0, 0, 5, 32'h401);
    setd(32'h108, 1, 0, 1, 3, 32'h500);
    setd(32'h110, 1, 0, 1, 20, 32'h600);
    setd(32'h118, 0, 0, 0, 0, 0);
    kick(); wait_idle();
    chk(first_addr == 32'h100, "R8", first_addr, 32'h100);
    expect_bytes(32'h401, 5, 0); expect_bytes(32'h500, 3, 1); expect_bytes(32'h600, 16, 1);
    compare("R5");
    counts("R7", 3, 2, 1);
    chk(mem[32'h100 >> 2] == {16'h0000, 16'd5}, "R7", mem[32'h100 >> 2], {16'h0000, 16'd5});
    chk(mem[32'h108 >> 2] == {16'h0800, 16'd3}, "R7", mem[32'h108 >> 2], {16'h0800, 16'd3});
    chk(mem[32'h110 >> 2] == {16'h0800, 16'd20}, "R6", mem[32'h110 >> 2], {16'h0800, 16'd20});
    chk(mem[32'h118 >> 2] == 32'h0, "R3", mem[32'h118 >> 2], 0);

    // R3 R4: resume at stopped slot, wrap back to ring start
    rdy_mode = 1;
    setd(32'h118, 1, 1, 1, 2, 32'h700);
    setd(32'h100, 1, 0, 1, 1, 32'h800);
    kick(); wait_idle();
    chk(first_addr == 32'h118, "R3", first_addr, 32'h118);
    expect_bytes(32'h700, 2, 1); expect_bytes(32'h800, 1, 1);
    compare("R4");
    counts("R4", 2, 2, 0);
    chk(mem[32'h118 >> 2] == {16'h2800, 16'd2}, "R7", mem[32'h118 >> 2], {16'h2800, 16'd2});

    // R6: truncation spread over descriptors, last one gets no room
    set_base(32'h180);
    setd(32'h180, 1, 0, 0, 10, 32'h640);
    setd(32'h188, 1, 0, 0, 10, 32'h680);
    setd(32'h190, 1, 0, 1, 3, 32'h6C0);
    setd(32'h198, 0, 0, 0, 0, 0);
    kick(); wait_idle();
    expect_bytes(32'h640, 10, 0); expect_bytes(32'h680, 6, 1);
    compare("R6");
    counts("R6", 3, 1, 2);

    // R8: unaligned ring start write
    set_base(32'h203);
    setd(32'h200, 1, 0, 1, 4, 32'h900);
    setd(32'h208, 0, 0, 0, 0, 0);
    kick(); wait_idle();
    chk(first_addr == 32'h200, "R8", first_addr, 32'h200);
    expect_bytes(32'h900, 4, 1);
    compare("R8");
    counts("R8", 1, 1, 0);

    // R2 R5: sweep of lengths and alignments through a one-slot ring
    set_base(32'h300);
    for (int len = 1; len <= 8; len++) begin
      for (int al = 0; al < 4; al++) begin
        rdy_mode = (len + al) % 2;
        setd(32'h300, 1, 1, 1, len, 32'hA00 + al);
        kick(); wait_idle();
        expect_bytes(32'hA00 + al, len, 1);
        compare("R2");
      end
    end
    counts("R7", 32, 32, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule